// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a virtual address into a physical frame number by reading translation entries from memory, one table level per read. A walk starts from a root table base and a mode. The mode selects one of three table formats. The first is a four-level format with 8-byte entries. The second is a three-level format with 8-byte entries and a small 32-byte-aligned top table. The third is a two-level format with 4-byte entries, which has a variant that may stop at the directory level on a large page.

The walker has a single memory read port and keeps at most one read outstanding. The port may refuse a request, or answer a read with a negative acknowledge. In both cases the walker parks the same request and sends it again when a retry pulse arrives. Every read carries the uncacheable flag given at start and an entry-width indicator.

A walk ends with a one-cycle result. The result holds either the frame number or a fault that names the level whose entry was not present. The block does not store translations, does not write back accessed or dirty bits, and checks no permission other than the present bit.

Top module: `pt_walker`

## Requirements
- R1: A start is taken only in a cycle where `start_ready` is high, which is the idle state. A `start_valid` while a walk is busy does not change the walk in progress.
- R2: Mode 0 reads four levels in the order 4, 3, 2, 1 with 8-byte entries. The entry offsets are VA[47:39], VA[38:30], VA[29:21] and VA[20:12], each times 8. The first table base is the root with its low 12 bits cleared.
- R3: Mode 1 reads three levels in the order 3, 2, 1 with 8-byte entries. The first read is at the root with its low 5 bits cleared, plus VA[31:30] times 8. Levels 2 and 1 use VA[29:21] and VA[20:12].
- R4: Mode 2 reads two levels, 2 then 1, with 4-byte entries. The offsets are VA[31:22] times 4 and VA[21:12] times 4. In this mode, bit 7 of a directory entry has no effect.
- R5: In mode 3, a present level-2 entry with bit 7 set ends the walk after one read. The frame is then {entry[31:22], VA[21:12]} and the result level is 2. With bit 7 clear, mode 3 walks like mode 2.
- R6: An entry with bit 0 clear ends the walk at once. The result has `res_fault`=1, `res_level` equal to that entry's level and a frame of 0, and no further read is issued.
- R7: The next table base, and the final frame of a walk ending at level 1, come from entry bits [PA_W-1:12] for 8-byte entries or bits [31:12] for 4-byte entries. A walk ending at level 1 reports level 1. Higher data bits are ignored.
- R8: Every read carries `mem_req_nc` equal to the start flag. `mem_req_wide` is 1 for 8-byte entries (modes 0 and 1) and 0 for modes 2 and 3.
- R9: A request that is refused (`mem_req_valid` high while `mem_req_ready` is low) is withdrawn and held. It is sent again with the same address after `mem_retry` is pulsed.
- R10: A read answered with `mem_rsp_nack` does not advance the walk. The same address is sent again after `mem_retry` is pulsed.
- R11: At most one read is outstanding. No request is raised between an accepted request and its response.
- R12: After reset, `start_ready`=1 and `mem_req_valid`=0 and `res_valid`=0. `res_valid` is a one-cycle pulse, and `start_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Walk request |
| start_ready | output | 1 | Walker idle, start taken |
| start_va | input | VA_W | Virtual address to translate |
| start_root | input | PA_W | Root table base |
| start_mode | input | 2 | 0 four-level, 1 three-level, 2 two-level, 3 two-level with large pages |
| start_nc | input | 1 | Uncacheable flag for the walk's reads |
| mem_req_valid | output | 1 | Read request |
| mem_req_ready | input | 1 | Request accepted; low refuses it |
| mem_req_addr | output | PA_W | Entry address |
| mem_req_wide | output | 1 | 1: 8-byte entry, 0: 4-byte entry |
| mem_req_nc | output | 1 | Uncacheable flag |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_nack | input | 1 | Response is a negative acknowledge |
| mem_rsp_data | input | 64 | Entry data (low 32 bits for 4-byte entries) |
| mem_retry | input | 1 | Re-send a held request |
| res_valid | output | 1 | Walk result pulse |
| res_fault | output | 1 | Entry not present |
| res_level | output | 3 | Level of the final or failing entry |
| res_frame | output | PA_W-12 | Physical frame number |

## Verification
The bench uses the default widths, a 48-bit virtual address and a 40-bit physical address. The 48-bit address lets the four-level index reach VA[47:39]. Because the physical width is below 52 bits, entries in the bench carry set bits above bit 39, and those bits must not leak into bases or frames. Upper-word garbage in 4-byte responses tests the same masking for the two-level modes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    MODE_L4  = 2'd0,
    MODE_L3  = 2'd1,
    MODE_L2  = 2'd2,
    MODE_L2B = 2'd3
  } walk_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD,
    ST_DONE
  } walk_state_e;

  function automatic logic [63:0] pa_mask(input int unsigned pa_w);
    return (64'd1 << pa_w) - 64'd1;
  endfunction

  function automatic logic [2:0] top_level(input walk_mode_e m);
    case (m)
      MODE_L4: return 3'd4;
      MODE_L3: return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic wide_entry(input walk_mode_e m);
    return (m == MODE_L4) || (m == MODE_L3);
  endfunction

  function automatic logic [9:0] level_index(input walk_mode_e m, input logic [2:0] lvl,
                                             input logic [63:0] va);
    logic w;
    w = wide_entry(m);
    case (lvl)
      3'd4: return {1'b0, va[47:39]};
      3'd3: return (m == MODE_L3) ? {8'd0, va[31:30]} : {1'b0, va[38:30]};
      3'd2: return w ? {1'b0, va[29:21]} : va[31:22];
      3'd1: return w ? {1'b0, va[20:12]} : va[21:12];
      default: return 10'd0;
    endcase
  endfunction

  function automatic logic [12:0] entry_offset(input walk_mode_e m, input logic [2:0] lvl,
                                               input logic [63:0] va);
    logic [9:0] idx;
    idx = level_index(m, lvl, va);
    return wide_entry(m) ? {idx, 3'b000} : {1'b0, idx, 2'b00};
  endfunction

  function automatic logic [63:0] root_base(input walk_mode_e m, input logic [63:0] root,
                                            input int unsigned pa_w);
    logic [63:0] keep;
    keep = (m == MODE_L3) ? ~64'h1F : ~64'hFFF;
    return root & keep & pa_mask(pa_w);
  endfunction

  function automatic logic [63:0] entry_view(input walk_mode_e m, input logic [63:0] data);
    return wide_entry(m) ? data : {32'd0, data[31:0]};
  endfunction

  function automatic logic [63:0] table_base(input walk_mode_e m, input logic [63:0] data,
                                             input int unsigned pa_w);
    return entry_view(m, data) & pa_mask(pa_w) & ~64'hFFF;
  endfunction

  function automatic logic big_leaf(input walk_mode_e m, input logic [2:0] lvl,
                                    input logic [63:0] data);
    return (m == MODE_L2B) && (lvl == 3'd2) && data[7];
  endfunction

  function automatic logic [63:0] frame_num(input walk_mode_e m, input logic [2:0] lvl,
                                            input logic [63:0] data, input logic [63:0] va,
                                            input int unsigned pa_w);
    if (big_leaf(m, lvl, data))
      return {44'd0, data[31:22], va[21:12]};
    return table_base(m, data, pa_w) >> 12;
  endfunction

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 40
) (
  input  logic [PA_W-1:0] base,
  input  logic [VA_W-1:0] va,
  input  walk_mode_e      mode,
  input  logic [2:0]      level,
  output logic [PA_W-1:0] addr,
  output logic            wide
);
  logic [12:0] offs;

  always_comb begin
    offs = entry_offset(mode, level, 64'(va));
    addr = base + PA_W'(offs);
    wide = wide_entry(mode);
  end
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 40,
  localparam int unsigned FRAME_W = PA_W - 12
) (
  input  logic [63:0]        data,
  input  logic [VA_W-1:0]    va,
  input  walk_mode_e         mode,
  input  logic [2:0]         level,
  output logic               present,
  output logic               leaf,
  output logic [PA_W-1:0]    next_base,
  output logic [FRAME_W-1:0] frame
);
  always_comb begin
    present   = data[0];
    leaf      = (level == 3'd1) || big_leaf(mode, level, data);
    next_base = PA_W'(table_base(mode, data, PA_W));
    frame     = FRAME_W'(frame_num(mode, level, data, 64'(va), PA_W));
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W = 48,
  parameter int unsigned PA_W = 40,
  localparam int unsigned FRAME_W = PA_W - 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [VA_W-1:0]    start_va,
  input  logic [PA_W-1:0]    start_root,
  input  logic [1:0]         start_mode,
  input  logic               start_nc,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic               mem_req_wide,
  output logic               mem_req_nc,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_nack,
  input  logic [63:0]        mem_rsp_data,
  input  logic               mem_retry,
  output logic               res_valid,
  output logic               res_fault,
  output logic [2:0]         res_level,
  output logic [FRAME_W-1:0] res_frame
);
  walk_state_e        state_q;
  walk_mode_e         mode_q;
  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    base_q;
  logic [2:0]         level_q;
  logic               nc_q;
  logic               fault_q;
  logic [2:0]         rlevel_q;
  logic [FRAME_W-1:0] frame_q;

  // named internal events
  logic start_fire, req_fire, req_refused, rsp_take, rsp_nacked, rsp_good;
  logic ent_present, ent_leaf;
  logic [PA_W-1:0]    ent_next_base;
  logic [FRAME_W-1:0] ent_frame;
  walk_mode_e         start_mode_e;

  assign start_mode_e  = walk_mode_e'(start_mode);
  assign start_ready   = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_nc    = nc_q;
  assign start_fire    = start_valid && start_ready;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign req_refused   = mem_req_valid && !mem_req_ready;
  assign rsp_take      = (state_q == ST_WAIT) && mem_rsp_valid;
  assign rsp_nacked    = rsp_take && mem_rsp_nack;
  assign rsp_good      = rsp_take && !mem_rsp_nack;
  assign res_valid     = (state_q == ST_DONE);
  assign res_fault     = fault_q;
  assign res_level     = rlevel_q;
  assign res_frame     = frame_q;

  ptw_addr_gen #(.VA_W(VA_W), .PA_W(PA_W)) u_addr (
    .base  (base_q),
    .va    (va_q),
    .mode  (mode_q),
    .level (level_q),
    .addr  (mem_req_addr),
    .wide  (mem_req_wide)
  );

  ptw_entry_eval #(.VA_W(VA_W), .PA_W(PA_W)) u_eval (
    .data      (mem_rsp_data),
    .va        (va_q),
    .mode      (mode_q),
    .level     (level_q),
    .present   (ent_present),
    .leaf      (ent_leaf),
    .next_base (ent_next_base),
    .frame     (ent_frame)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= MODE_L4;
      va_q     <= '0;
      base_q   <= '0;
      level_q  <= 3'd0;
      nc_q     <= 1'b0;
      fault_q  <= 1'b0;
      rlevel_q <= 3'd0;
      frame_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_fire) begin
          va_q    <= start_va;
          mode_q  <= start_mode_e;
          nc_q    <= start_nc;
          base_q  <= PA_W'(root_base(start_mode_e, 64'(start_root), PA_W));
          level_q <= top_level(start_mode_e);
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: state_q <= req_fire ? ST_WAIT : ST_HOLD;
        ST_HOLD:  if (mem_retry) state_q <= ST_ISSUE;
        ST_WAIT: begin
          if (rsp_nacked) begin
            state_q <= ST_HOLD;
          end else if (rsp_good) begin
            if (!ent_present) begin
              fault_q  <= 1'b1;
              rlevel_q <= level_q;
              frame_q  <= '0;
              state_q  <= ST_DONE;
            end else if (ent_leaf) begin
              fault_q  <= 1'b0;
              rlevel_q <= level_q;
              frame_q  <= ent_frame;
              state_q  <= ST_DONE;
            end else begin
              base_q  <= ent_next_base;
              level_q <= level_q - 3'd1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && !start_ready) |=> ($stable(va_q) && $stable(mode_q))); // R1
  AST_LEVEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (level_q >= 3'd1 && level_q <= 3'd4)); // R2
  AST_FAULT_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_level != 3'd0 && res_frame == '0)); // R6
  AST_REFUSED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_refused |=> (!mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_nc))); // R9
  AST_NACK_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_nacked |=> (!mem_req_valid && $stable(level_q) && $stable(mem_req_addr))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid); // R11
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && start_ready)); // R12
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  localparam int VA = 48;
  localparam int PA = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [VA-1:0] start_va = '0;
  logic [PA-1:0] start_root = '0;
  logic [1:0] start_mode = 2'd0;
  logic start_nc = 1'b0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [PA-1:0] mem_req_addr;
  logic mem_req_wide, mem_req_nc;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_nack = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic mem_retry = 1'b0;
  logic res_valid, res_fault;
  logic [2:0] res_level;
  logic [PA-13:0] res_frame;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pt_walker #(.VA_W(VA), .PA_W(PA)) dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready), .start_va(start_va),
    .start_root(start_root), .start_mode(start_mode), .start_nc(start_nc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_wide(mem_req_wide), .mem_req_nc(mem_req_nc),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_nack(mem_rsp_nack),
    .mem_rsp_data(mem_rsp_data), .mem_retry(mem_retry),
    .res_valid(res_valid), .res_fault(res_fault), .res_level(res_level),
    .res_frame(res_frame)
  );

  task automatic check(input string rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // bench-side address arithmetic
  function automatic logic [PA-1:0] ix(input logic [VA-1:0] va, input int sh, input int bits);
    return PA'((va >> sh) % (48'd1 << bits));
  endfunction

  task automatic wait_req(input string rq);
    int n = 0;
    while (!mem_req_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(rq, "request seen", 64'(mem_req_valid), 64'd1);
  endtask

  task automatic start_walk(input logic [1:0] m, input logic [VA-1:0] va,
                            input logic [PA-1:0] root, input bit nc);
    @(negedge clk);
    start_mode = m; start_va = va; start_root = root; start_nc = nc; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic serve(input logic [PA-1:0] ea, input bit ew, input bit enc,
                       input logic [63:0] d, input string rq, input bit refuse, input bit nack);
    mem_req_ready = !refuse;
    wait_req(rq);
    check(rq, "req addr", 64'(mem_req_addr), 64'(ea));
    check("R8", "req wide", 64'(mem_req_wide), 64'(ew));
    check("R8", "req nc", 64'(mem_req_nc), 64'(enc));
    if (refuse) begin
      @(negedge clk);
      check("R9", "withdrawn after refusal", 64'(mem_req_valid), 64'd0);
      repeat (3) @(negedge clk);
      check("R9", "held without retry", 64'(mem_req_valid), 64'd0);
      mem_retry = 1'b1;
      @(negedge clk);
      mem_retry = 1'b0;
      mem_req_ready = 1'b1;
      check("R9", "reissued", 64'(mem_req_valid), 64'd1);
      check("R9", "reissued addr", 64'(mem_req_addr), 64'(ea));
    end
    @(negedge clk);
    if (nack) begin
      mem_rsp_valid = 1'b1; mem_rsp_nack = 1'b1; mem_rsp_data = d;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_nack = 1'b0;
      check("R10", "no request after nack", 64'(mem_req_valid), 64'd0);
      mem_retry = 1'b1;
      @(negedge clk);
      mem_retry = 1'b0;
      check("R10", "reissued after nack", 64'(mem_req_valid), 64'd1);
      check("R10", "same addr after nack", 64'(mem_req_addr), 64'(ea));
      @(negedge clk);
    end
    check("R11", "no request while outstanding", 64'(mem_req_valid), 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = d;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic expect_result(input bit f, input logic [2:0] lv, input logic [PA-13:0] fr,
                               input string rq);
    int n = 0;
    while (!res_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(rq, "result seen", 64'(res_valid), 64'd1);
    check(rq, "fault", 64'(res_fault), 64'(f));
    check(rq, "level", 64'(res_level), 64'(lv));
    check(rq, "frame", 64'(res_frame), 64'(fr));
    @(negedge clk);
    check("R12", "result one cycle", 64'(res_valid), 64'd0);
    check("R12", "ready after result", 64'(start_ready), 64'd1);
    check(rq, "no read after end", 64'(mem_req_valid), 64'd0);
  endtask

  localparam logic [VA-1:0] VA_L4 = 48'h7F12_3456_7890;

  task automatic t_reset();
    check("R12", "reset start_ready", 64'(start_ready), 64'd1);
    check("R12", "reset req", 64'(mem_req_valid), 64'd0);
    check("R12", "reset result", 64'(res_valid), 64'd0);
  endtask

  // R2 R7: four-level walk, bits above PA width in entries
  task automatic t_four_level(input bit nack_second);
    logic [PA-1:0] b = 40'h00_0010_0000;
    start_walk(2'd0, VA_L4, 40'h00_0010_0ABC, 1'b0);
    serve(b + ix(VA_L4, 39, 9) * 8, 1, 0, 64'h80F0_0000_0020_0003, "R2", 0, 0);
    serve(40'h20_0000 + ix(VA_L4, 30, 9) * 8, 1, 0, 64'h0000_0000_0030_0001, "R2", 0, nack_second);
    serve(40'h30_0000 + ix(VA_L4, 21, 9) * 8, 1, 0, 64'h0000_0000_0040_0067, "R2", 0, 0);
    serve(40'h40_0000 + ix(VA_L4, 12, 9) * 8, 1, 0, 64'h7FF0_0012_3456_7005, "R7", 0, 0);
    expect_result(0, 3'd1, 28'h123_4567, "R7");
  endtask

  // R3 R9: three-level walk, first request refused, uncacheable
  task automatic t_three_level();
    logic [VA-1:0] va = 48'h0000_C030_5123;
    start_walk(2'd1, va, 40'h00_0000_1F27, 1'b1);
    serve(40'h1F38, 1, 1, 64'h0000_0000_0050_0001, "R3", 1, 0);
    serve(40'h50_0000 + ix(va, 21, 9) * 8, 1, 1, 64'h0000_0000_0060_0001, "R3", 0, 0);
    serve(40'h60_0000 + ix(va, 12, 9) * 8, 1, 1, 64'h0000_0000_0ABC_D001, "R3", 0, 0);
    expect_result(0, 3'd1, 28'h000_ABCD, "R3");
  endtask

  // R4 R7: two-level, bit 7 set must not end the walk, upper word ignored
  task automatic t_two_level();
    logic [VA-1:0] va = 48'h0000_8040_3ABC;
    start_walk(2'd2, va, 40'h00_0000_7123, 1'b0);
    serve(40'h7804, 0, 0, 64'hFFFF_FFFF_0000_9083, "R4", 0, 0);
    serve(40'h900C, 0, 0, 64'hDEAD_BEEF_ABCD_E001, "R4", 0, 0);
    expect_result(0, 3'd1, 28'h00A_BCDE, "R4");
  endtask

  // R5: large-page leaf, and the same mode without the size bit
  task automatic t_large_page();
    logic [VA-1:0] va = 48'h0000_1234_5678;
    start_walk(2'd3, va, 40'h00_0000_3000, 1'b0);
    serve(40'h3120, 0, 0, 64'h0000_0000_C040_0083, "R5", 0, 0);
    expect_result(0, 3'd2, 28'h00C_0745, "R5");
    start_walk(2'd3, va, 40'h00_0000_3000, 1'b0);
    serve(40'h3120, 0, 0, 64'h0000_0000_0000_8001, "R5", 0, 0);
    serve(40'h8D14, 0, 0, 64'h0000_0000_0777_7001, "R5", 0, 0);
    expect_result(0, 3'd1, 28'h000_7777, "R5");
  endtask

  // R6: not-present entries at two different levels
  task automatic t_faults();
    logic [VA-1:0] va = 48'h0000_C030_5123;
    start_walk(2'd0, VA_L4, 40'h00_0010_0000, 1'b0);
    serve(40'h10_0000 + ix(VA_L4, 39, 9) * 8, 1, 0, 64'h0000_0000_0020_0003, "R6", 0, 0);
    serve(40'h20_0000 + ix(VA_L4, 30, 9) * 8, 1, 0, 64'h0000_0000_0030_0001, "R6", 0, 0);
    serve(40'h30_0000 + ix(VA_L4, 21, 9) * 8, 1, 0, 64'h0000_0000_0040_0066, "R6", 0, 0);
    expect_result(1, 3'd2, 28'h0, "R6");
    start_walk(2'd1, va, 40'h00_0000_1F00, 1'b0);
    serve(40'h1F18, 1, 0, 64'h0000_0000_0050_0000, "R6", 0, 0);
    expect_result(1, 3'd3, 28'h0, "R6");
  endtask

  // R1: a start held high during a busy walk changes nothing
  task automatic t_busy_start();
    logic [VA-1:0] va = 48'h0000_8040_3ABC;
    start_walk(2'd2, va, 40'h00_0000_7000, 1'b0);
    start_mode = 2'd0; start_va = 48'hFFFF_FFFF_FFFF; start_root = 40'hFF_FFFF_F000;
    start_nc = 1'b1; start_valid = 1'b1;
    check("R1", "busy start_ready", 64'(start_ready), 64'd0);
    serve(40'h7804, 0, 0, 64'h0000_0000_0000_9001, "R1", 0, 0);
    serve(40'h900C, 0, 0, 64'h0000_0000_1111_1001, "R1", 0, 0);
    start_valid = 1'b0;
    expect_result(0, 3'd1, 28'h001_1111, "R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_four_level(0);
    t_three_level();
    t_two_level();
    t_large_page();
    t_faults();
    t_four_level(1);   // R10 nack on the second read
    t_busy_start();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule